// File: doc/BRIEF.md
# Sample Threshold Comparator

This block is a digital threshold checker for one converter channel. Each cycle it may receive a new sample from one of two sources: the raw conversion result or the processed channel value. A select input picks the source. When the selected source strobes a sample, the block tests it against a low and a high threshold. The test uses one of four encoded criteria. Matching samples advance a match counter. That counter runs in one of two styles. In back-to-back style a miss clears the counter. In accumulating style misses are ignored.

When the counter meets its programmed condition, the block fires an event. An event sets a sticky compare flag, raises a one-cycle interrupt pulse and returns the counter to zero. The live count is available as an output at all times.

Samples arrive as valid-only streams with no ready signal. The block accepts a strobed sample in every cycle and never applies back-pressure, so a producer may strobe on consecutive cycles. A strobe on the source that is not selected is dropped. All thresholds and sample values are 16-bit unsigned.

Top module: `thr_compare`

## Requirements
- R1: A sample is evaluated only in a cycle where the strobe of the selected source is high. `src_sel`=0 selects `raw_data`/`raw_valid` and `src_sel`=1 selects `proc_data`/`proc_valid`. A strobe on the other source leaves the count, flag and interrupt unchanged.
- R2: With `cmp_mode`=3'b001, a sample matches when it is strictly below `thr_lo` or strictly above `thr_hi`.
- R3: With `cmp_mode`=3'b010, a sample matches when `thr_lo` <= value <= `thr_hi`.
- R4: With `cmp_mode`=3'b011, a sample matches when value >= `thr_lo`, and `thr_hi` is ignored.
- R5: With `cmp_mode`=3'b100, a sample matches when value <= `thr_lo`.
- R6: With `cmp_mode` set to 3'b000, 3'b101, 3'b110 or 3'b111, no sample ever matches and no event fires.
- R7: With `count_cumulative`=0, each matching sample raises `match_cnt` by one and a miss clears it to 0. An event fires on the match that brings the count to at least `match_limit`, so a limit of 0 behaves like a limit of 1.
- R8: With `count_cumulative`=1, a miss leaves `match_cnt` unchanged. An event fires on the match that makes the count greater than `match_limit`, which is the (limit+1)-th counted match.
- R9: When an event fires, `match_cnt` becomes 0, `cmp_flag` becomes 1 and `cmp_irq` is high for exactly one cycle. All three outputs show this on the clock edge that takes the sample.
- R10: `cmp_flag` stays set until a cycle with `flag_clr`=1. If an event fires in that same cycle, the flag stays set.
- R11: `match_cnt` saturates at 1023. With accumulating style and a limit of 1023, the count holds at 1023 and no event fires.
- R12: After reset, `match_cnt` is 0, `cmp_flag` is 0 and `cmp_irq` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| raw_data | input | 16 | Raw conversion sample |
| raw_valid | input | 1 | Strobe for raw_data |
| proc_data | input | 16 | Processed channel sample |
| proc_valid | input | 1 | Strobe for proc_data |
| src_sel | input | 1 | 0 selects the raw source, 1 selects the processed source |
| cmp_mode | input | 3 | Criterion code |
| count_cumulative | input | 1 | 0 for back-to-back counting, 1 for accumulating |
| thr_lo | input | 16 | Low threshold |
| thr_hi | input | 16 | High threshold |
| match_limit | input | 10 | Event count limit |
| flag_clr | input | 1 | Write-one-to-clear pulse for cmp_flag |
| match_cnt | output | 10 | Live match count |
| cmp_flag | output | 1 | Sticky event flag |
| cmp_irq | output | 1 | One-cycle event pulse |

## Verification
Saturation is the state that takes the longest to reach from the ports. It needs more than a thousand matching samples with accumulating style and the maximum limit. The stimulus strobes a matching sample on every cycle until the count pins. It then checks that further matches neither wrap the count nor fire. A second hard case is an event that lands in the same cycle as a flag clear. The bench lines these up by asserting the clear alongside the firing sample. Each criterion's edges are covered by a vector table that runs with accumulating style and a limit of 0. In that setting, every match shows up directly as an interrupt.

// File: rtl/thrcmp_pkg.sv
package thrcmp_pkg;
  typedef enum logic [2:0] {
    CMP_OFF      = 3'b000,
    CMP_OUTSIDE  = 3'b001,
    CMP_INSIDE   = 3'b010,
    CMP_AT_LEAST = 3'b011,
    CMP_AT_MOST  = 3'b100
  } cmp_mode_e;
endpackage

// File: rtl/src_select.sv
module src_select #(
  parameter int W     = 16,
  parameter int N_SRC = 2,
  localparam int SW   = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic [N_SRC-1:0][W-1:0] data_in,
  input  logic [N_SRC-1:0]        valid_in,
  input  logic [SW-1:0]           sel,
  output logic [W-1:0]            data_out,
  output logic                    valid_out
);
  logic [N_SRC-1:0] pick;

  for (genvar i = 0; i < N_SRC; i++) begin : g_pick
    assign pick[i] = (sel == SW'(i));
  end

  always_comb begin
    data_out  = '0;
    valid_out = 1'b0;
    for (int i = 0; i < N_SRC; i++) begin
      if (pick[i]) begin
        data_out  = data_in[i];
        valid_out = valid_in[i];
      end
    end
  end
endmodule

// File: rtl/threshold_match.sv
module threshold_match
  import thrcmp_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] value,
  input  logic [W-1:0] lo,
  input  logic [W-1:0] hi,
  input  logic [2:0]   mode,
  output logic         hit
);
  logic below_lo, above_hi;

  assign below_lo = value < lo;
  assign above_hi = value > hi;

  always_comb begin
    case (cmp_mode_e'(mode))
      CMP_OUTSIDE:  hit = below_lo | above_hi;
      CMP_INSIDE:   hit = !below_lo && !above_hi;
      CMP_AT_LEAST: hit = !below_lo;
      CMP_AT_MOST:  hit = (value <= lo);
      default:      hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/match_counter.sv
module match_counter #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sample,
  input  logic             hit,
  input  logic             cumulative,
  input  logic [CNT_W-1:0] limit,
  output logic [CNT_W-1:0] count,
  output logic             fire
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   inc_w;
  logic [CNT_W-1:0] next_sat;
  logic             reached;

  assign inc_w    = {1'b0, cnt_q} + 1'b1;
  assign next_sat = inc_w[CNT_W] ? CNT_MAX : inc_w[CNT_W-1:0];
  assign reached  = cumulative ? (next_sat > limit) : (next_sat >= limit);
  assign fire     = sample && hit && reached;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (sample) begin
      if (hit) begin
        cnt_q <= fire ? '0 : next_sat;
      end else if (!cumulative) begin
        cnt_q <= '0;
      end
    end
  end

  assign count = cnt_q;
endmodule

// File: rtl/thr_compare.sv
module thr_compare #(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] raw_data,
  input  logic              raw_valid,
  input  logic [DATA_W-1:0] proc_data,
  input  logic              proc_valid,
  input  logic              src_sel,
  input  logic [2:0]        cmp_mode,
  input  logic              count_cumulative,
  input  logic [DATA_W-1:0] thr_lo,
  input  logic [DATA_W-1:0] thr_hi,
  input  logic [CNT_W-1:0]  match_limit,
  input  logic              flag_clr,
  output logic [CNT_W-1:0]  match_cnt,
  output logic              cmp_flag,
  output logic              cmp_irq
);
  logic [DATA_W-1:0] value;
  logic              sample;
  logic              hit;
  logic              fire;
  logic              flag_q, irq_q;

  src_select #(.W(DATA_W), .N_SRC(2)) u_sel (
    .data_in  ({proc_data, raw_data}),
    .valid_in ({proc_valid, raw_valid}),
    .sel      (src_sel),
    .data_out (value),
    .valid_out(sample)
  );

  threshold_match #(.W(DATA_W)) u_match (
    .value(value),
    .lo   (thr_lo),
    .hi   (thr_hi),
    .mode (cmp_mode),
    .hit  (hit)
  );

  match_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .sample    (sample),
    .hit       (hit),
    .cumulative(count_cumulative),
    .limit     (match_limit),
    .count     (match_cnt),
    .fire      (fire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      irq_q <= fire;
      if (fire)          flag_q <= 1'b1;
      else if (flag_clr) flag_q <= 1'b0;
    end
  end

  assign cmp_flag = flag_q;
  assign cmp_irq  = irq_q;
endmodule

// File: rtl/thr_compare_chk.sv
module thr_compare_chk #(
  parameter int CNT_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             raw_valid,
  input logic             proc_valid,
  input logic             src_sel,
  input logic [2:0]       cmp_mode,
  input logic             count_cumulative,
  input logic             flag_clr,
  input logic [CNT_W-1:0] match_cnt,
  input logic             cmp_flag,
  input logic             cmp_irq
);
  logic sel_valid;
  logic mode_off;

  assign sel_valid = src_sel ? proc_valid : raw_valid;
  assign mode_off  = (cmp_mode == 3'b000) || (cmp_mode > 3'b100);

  a_r9_irq_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_irq |-> cmp_flag);

  a_r9_irq_zero_count: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_irq |-> (match_cnt == '0));

  a_r1_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_valid |=> ($stable(match_cnt) && !cmp_irq));

  a_r6_off_no_event: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_valid && mode_off) |=> !cmp_irq);

  a_r10_fall_needs_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cmp_flag) |-> $past(flag_clr));

  a_r7_consec_step: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_valid && !count_cumulative) |=>
      (match_cnt == '0 || match_cnt == $past(match_cnt) + 1'b1));
endmodule

bind thr_compare thr_compare_chk #(.CNT_W(CNT_W)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .raw_valid       (raw_valid),
  .proc_valid      (proc_valid),
  .src_sel         (src_sel),
  .cmp_mode        (cmp_mode),
  .count_cumulative(count_cumulative),
  .flag_clr        (flag_clr),
  .match_cnt       (match_cnt),
  .cmp_flag        (cmp_flag),
  .cmp_irq         (cmp_irq)
);

// File: tb/thr_compare_tb.sv
module thr_compare_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] raw_data = '0, proc_data = '0, thr_lo = '0, thr_hi = '0;
  logic        raw_valid = 1'b0, proc_valid = 1'b0, src_sel = 1'b0;
  logic [2:0]  cmp_mode = '0;
  logic        count_cumulative = 1'b0, flag_clr = 1'b0;
  logic [9:0]  match_limit = '0;
  logic [9:0]  match_cnt;
  logic        cmp_flag, cmp_irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  thr_compare u_dut (
    .clk(clk), .rst_n(rst_n),
    .raw_data(raw_data), .raw_valid(raw_valid),
    .proc_data(proc_data), .proc_valid(proc_valid),
    .src_sel(src_sel), .cmp_mode(cmp_mode),
    .count_cumulative(count_cumulative),
    .thr_lo(thr_lo), .thr_hi(thr_hi),
    .match_limit(match_limit), .flag_clr(flag_clr),
    .match_cnt(match_cnt), .cmp_flag(cmp_flag), .cmp_irq(cmp_irq)
  );

  typedef struct packed {
    logic [2:0]  mode;
    logic        sel;
    logic [15:0] raw;
    logic [15:0] prc;
    logic        exp;
  } vec_t;

  localparam int NV = 26;
  localparam vec_t VEC [NV] = '{
    '{3'b001, 1'b0, 16'd99,  16'd0,   1'b1},  // R2
    '{3'b001, 1'b0, 16'd100, 16'd0,   1'b0},
    '{3'b001, 1'b0, 16'd200, 16'd0,   1'b0},
    '{3'b001, 1'b0, 16'd201, 16'd0,   1'b1},
    '{3'b010, 1'b0, 16'd99,  16'd0,   1'b0},  // R3
    '{3'b010, 1'b0, 16'd100, 16'd0,   1'b1},
    '{3'b010, 1'b0, 16'd200, 16'd0,   1'b1},
    '{3'b010, 1'b0, 16'd201, 16'd0,   1'b0},
    '{3'b011, 1'b0, 16'd99,  16'd0,   1'b0},  // R4
    '{3'b011, 1'b0, 16'd100, 16'd0,   1'b1},
    '{3'b011, 1'b0, 16'd500, 16'd0,   1'b1},
    '{3'b100, 1'b0, 16'd100, 16'd0,   1'b1},  // R5
    '{3'b100, 1'b0, 16'd101, 16'd0,   1'b0},
    '{3'b100, 1'b0, 16'd0,   16'd0,   1'b1},
    '{3'b010, 1'b1, 16'd150, 16'd50,  1'b0},  // R1
    '{3'b010, 1'b1, 16'd50,  16'd150, 1'b1},
    '{3'b001, 1'b1, 16'd150, 16'd300, 1'b1},
    '{3'b100, 1'b1, 16'd0,   16'd150, 1'b0},
    '{3'b000, 1'b0, 16'd150, 16'd0,   1'b0},  // R6
    '{3'b000, 1'b0, 16'd50,  16'd0,   1'b0},
    '{3'b101, 1'b0, 16'd150, 16'd0,   1'b0},
    '{3'b101, 1'b0, 16'd50,  16'd0,   1'b0},
    '{3'b110, 1'b0, 16'd150, 16'd0,   1'b0},
    '{3'b110, 1'b1, 16'd0,   16'd50,  1'b0},
    '{3'b111, 1'b0, 16'd150, 16'd0,   1'b0},
    '{3'b111, 1'b1, 16'd0,   16'd300, 1'b0}
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic put(input logic s, input logic rv, input logic pv,
                     input logic [15:0] rd, input logic [15:0] pd);
    src_sel = s; raw_valid = rv; proc_valid = pv; raw_data = rd; proc_data = pd;
    @(posedge clk);
    @(negedge clk);
    raw_valid = 1'b0; proc_valid = 1'b0; flag_clr = 1'b0;
  endtask

  task automatic idle();
    @(posedge clk);
    @(negedge clk);
    flag_clr = 1'b0;
  endtask

  task automatic clear_flag();
    flag_clr = 1'b1;
    idle();
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int irq_seen;
    repeat (3) @(negedge clk);
    chk(match_cnt == 0, "R12", "reset count", match_cnt, 0);
    chk(cmp_flag == 0, "R12", "reset flag", cmp_flag, 0);
    chk(cmp_irq == 0, "R12", "reset irq", cmp_irq, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // Table: accumulating style, limit 0, so each match fires at once.
    thr_lo = 16'd100; thr_hi = 16'd200;
    count_cumulative = 1'b1; match_limit = 10'd0;
    for (int i = 0; i < NV; i++) begin
      cmp_mode = VEC[i].mode;
      put(VEC[i].sel, !VEC[i].sel, VEC[i].sel, VEC[i].raw, VEC[i].prc);
      chk(cmp_irq == VEC[i].exp, "R2-R6 vector", $sformatf("vec %0d irq", i),
          cmp_irq, VEC[i].exp);
      chk(match_cnt == 0, "R9", $sformatf("vec %0d count", i), match_cnt, 0);
      clear_flag();
    end

    // R1: the unselected strobe is dropped.
    cmp_mode = 3'b010; match_limit = 10'd5;
    put(1'b0, 1'b0, 1'b1, 16'd0, 16'd150);
    chk(match_cnt == 0, "R1", "proc strobe while raw selected", match_cnt, 0);
    put(1'b1, 1'b1, 1'b0, 16'd150, 16'd0);
    chk(match_cnt == 0, "R1", "raw strobe while proc selected", match_cnt, 0);
    put(1'b1, 1'b0, 1'b1, 16'd0, 16'd150);
    chk(match_cnt == 1, "R1", "selected proc strobe counts", match_cnt, 1);

    // R8: accumulating style, limit 2, with misses in between.
    match_limit = 10'd2;
    put(1'b0, 1'b1, 1'b0, 16'd50, 16'd0);
    chk(match_cnt == 1, "R8", "miss keeps count", match_cnt, 1);
    put(1'b0, 1'b1, 1'b0, 16'd150, 16'd0);
    chk(match_cnt == 2 && !cmp_irq, "R8", "count at limit, no event", match_cnt, 2);
    put(1'b0, 1'b1, 1'b0, 16'd40, 16'd0);
    put(1'b0, 1'b1, 1'b0, 16'd150, 16'd0);
    chk(cmp_irq == 1, "R8", "event on limit+1 match", cmp_irq, 1);
    chk(match_cnt == 0, "R9", "count reset after event", match_cnt, 0);
    clear_flag();

    // R7: back-to-back style, limit 3.
    count_cumulative = 1'b0; match_limit = 10'd3;
    put(1'b0, 1'b1, 1'b0, 16'd150, 16'd0);
    put(1'b0, 1'b1, 1'b0, 16'd150, 16'd0);
    chk(match_cnt == 2, "R7", "two matches", match_cnt, 2);
    put(1'b0, 1'b1, 1'b0, 16'd50, 16'd0);
    chk(match_cnt == 0, "R7", "miss clears", match_cnt, 0);
    put(1'b0, 1'b1, 1'b0, 16'd150, 16'd0);
    put(1'b0, 1'b1, 1'b0, 16'd150, 16'd0);
    chk(cmp_irq == 0, "R7", "no event before limit", cmp_irq, 0);
    put(1'b0, 1'b1, 1'b0, 16'd150, 16'd0);
    chk(cmp_irq == 1, "R7", "event at limit", cmp_irq, 1);
    chk(cmp_flag == 1, "R9", "flag set on event", cmp_flag, 1);
    chk(match_cnt == 0, "R9", "count zero on event", match_cnt, 0);
    idle();
    chk(cmp_irq == 0, "R9", "irq lasts one cycle", cmp_irq, 0);
    chk(cmp_flag == 1, "R10", "flag sticky", cmp_flag, 1);
    clear_flag();
    chk(cmp_flag == 0, "R10", "flag cleared", cmp_flag, 0);

    // R7: limit 0 fires on the first match.
    match_limit = 10'd0;
    put(1'b0, 1'b1, 1'b0, 16'd150, 16'd0);
    chk(cmp_irq == 1, "R7", "limit 0 fires on first match", cmp_irq, 1);

    // R10: the event wins over a clear in the same cycle.
    flag_clr = 1'b1;
    put(1'b0, 1'b1, 1'b0, 16'd150, 16'd0);
    chk(cmp_flag == 1, "R10", "set wins over clear", cmp_flag, 1);
    clear_flag();

    // R11: saturation with accumulating style and limit 1023.
    count_cumulative = 1'b1; match_limit = 10'd1023;
    irq_seen = 0;
    for (int i = 0; i < 1023; i++) begin
      put(1'b0, 1'b1, 1'b0, 16'd150, 16'd0);
      if (cmp_irq) irq_seen++;
    end
    chk(match_cnt == 1023, "R11", "count reaches max", match_cnt, 1023);
    for (int i = 0; i < 20; i++) begin
      put(1'b0, 1'b1, 1'b0, 16'd150, 16'd0);
      if (cmp_irq) irq_seen++;
    end
    chk(match_cnt == 1023, "R11", "count holds at max", match_cnt, 1023);
    chk(irq_seen == 0, "R11", "no event while saturated", irq_seen, 0);
    chk(cmp_flag == 0, "R11", "flag stays clear", cmp_flag, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule